// File: doc/BRIEF.md
# Paged Address Translation Protection Unit

This block turns a 16-bit word virtual address into a physical word address through one of four page tables. Each table has one entry per 1K-word page, so it has 64 entries. The table is chosen by a small control register for each interrupt level, which also carries the ring of the running program. Every entry holds a physical page number, three access permits (write, read, fetch), a two-bit page ring, and two status bits: used and written.

A request is accepted in one cycle. The answer appears on the next cycle: the physical address, a memory strobe, or one of two fault pulses (page fault, protection violation). When a translation succeeds, the status bits of the entry are updated. A faulting access leaves them alone. When paging is disabled, the virtual address goes straight out with no checks.

The control registers and the table entries are filled through two plain write ports. Fault capture and physical memory are outside the block.

Top module: `pgx_xlate`

## Requirements
- R1: With paging on and no fault, `rsp_pa` equals the entry's physical page number shifted left by 10, joined with virtual address bits 9:0. The page number used for the lookup is virtual address bits 15:10.
- R2: The table used for a normal access is the field at bits 10:9 of the control register of `req_lvl`. The user ring is bits 1:0 of that register. All other bits written to the register are discarded.
- R3: When `req_alt` is 1 on a read or a write, the table number comes from control register bits 8:7. On a fetch, `req_alt` has no effect.
- R4: An entry whose three permits (bit 15 write, bit 14 read, bit 13 fetch) are all clear raises `rsp_pf` only, never `rsp_pv`.
- R5: If some permit is set but the one the access needs is clear, `rsp_pv` is raised. A fetch (kind 1) needs bit 13, a read (kind 0) needs bit 14, and a write (kind 2) needs bit 15.
- R6: If the needed permit is present but the page ring (entry bits 10:9) is greater than the user ring, `rsp_pv` is raised.
- R7: A successful read or fetch sets the entry's used bit. A successful write sets both used and written. `rsp_used` and `rsp_written` show the entry's status after the access.
- R8: A faulting access gives `rsp_mem` = 0 and leaves the entry's status bits unchanged.
- R9: With `req_pon` = 0, `rsp_pa` is the virtual address zero-extended and `rsp_mem` is 1. No fault is raised, `rsp_used` and `rsp_written` read 0, and no status bit changes.
- R10: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high.
- R11: After reset, `rsp_valid`, `rsp_mem`, `rsp_pf` and `rsp_pv` are 0.
- R12: A table write stores bits 15:13 (permits), bits 10:9 (ring) and the low `PPN_W` bits (page number). It loads the written and used status from bits 12 and 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write a level control register |
| cfg_lvl | input | LVL_W | Level whose control register is written |
| cfg_data | input | 16 | Control word: bits 10:9 normal table, 8:7 alternate table, 1:0 user ring |
| tbl_we | input | 1 | Write a table entry |
| tbl_sel | input | 2 | Table number for the write |
| tbl_page | input | VA_W-OFS_W | Page index for the write |
| tbl_data | input | 16 | Entry word in the layout of R12 |
| req_valid | input | 1 | Translation request |
| req_va | input | VA_W | Virtual word address |
| req_kind | input | 2 | 0 read, 1 fetch, 2 write |
| req_alt | input | 1 | Use the alternate table (read or write only) |
| req_lvl | input | LVL_W | Current interrupt level |
| req_pon | input | 1 | Paging enabled |
| rsp_valid | output | 1 | Result valid |
| rsp_pa | output | PPN_W+OFS_W | Physical word address |
| rsp_mem | output | 1 | Memory strobe (access allowed) |
| rsp_pf | output | 1 | Page fault pulse |
| rsp_pv | output | 1 | Protection violation pulse |
| rsp_used | output | 1 | Used status of the entry after the access |
| rsp_written | output | 1 | Written status of the entry after the access |

## Verification
The bench keeps the default parameters: 16-bit addresses, 1K-word pages, 9-bit page numbers and 16 levels. With these, all 256 entries of the four tables can be loaded, and every permit combination and page ring appears eight times or more. Every level, page, access kind and alternate-flag setting is swept. This covers each fault priority against each user ring and both table fields of every control register. A model in the bench follows the status bits, so each used or written bit set by an earlier access is checked again by later accesses.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

    // access kinds as driven on req_kind
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_FETCH = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        VERD_OK = 2'd0,
        VERD_PF = 2'd1,
        VERD_PV = 2'd2
    } verdict_e;

    // fixed table count: the control register fields are two bits wide
    localparam int NUM_TABLES = 4;
    localparam int TSEL_W     = 2;

    // entry word layout
    localparam int E_WR_BIT   = 15;
    localparam int E_RD_BIT   = 14;
    localparam int E_FE_BIT   = 13;
    localparam int E_WRITTEN  = 12;
    localparam int E_USED     = 11;
    localparam int E_RING_LO  = 9;

    // control word layout
    localparam int C_NORM_LO  = 9;
    localparam int C_ALT_LO   = 7;
    localparam int C_RING_LO  = 0;

    typedef struct packed {
        logic       wr_ok;
        logic       rd_ok;
        logic       fe_ok;
        logic [1:0] ring;
    } perm_t;

    localparam int PERM_W = $bits(perm_t);

    typedef struct packed {
        logic [TSEL_W-1:0] norm_tbl;
        logic [TSEL_W-1:0] alt_tbl;
        logic [1:0]        ring;
    } ctl_t;

    function automatic perm_t perm_from_word(input logic [15:0] w);
        perm_t p;
        p.wr_ok = w[E_WR_BIT];
        p.rd_ok = w[E_RD_BIT];
        p.fe_ok = w[E_FE_BIT];
        p.ring  = w[E_RING_LO +: 2];
        return p;
    endfunction

    function automatic ctl_t ctl_from_word(input logic [15:0] w);
        ctl_t c;
        c.norm_tbl = w[C_NORM_LO +: TSEL_W];
        c.alt_tbl  = w[C_ALT_LO +: TSEL_W];
        c.ring     = w[C_RING_LO +: 2];
        return c;
    endfunction

    function automatic logic needed_permit(input acc_e k, input perm_t p);
        case (k)
            ACC_FETCH: return p.fe_ok;
            ACC_WRITE: return p.wr_ok;
            default:   return p.rd_ok;
        endcase
    endfunction

endpackage

// File: rtl/pgx_ctl_regs.sv
module pgx_ctl_regs
    import pgx_pkg::*;
#(
    parameter int LEVELS = 16,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [LVL_W-1:0] wlvl,
    input  logic [15:0]      wdata,
    input  logic [LVL_W-1:0] rlvl,
    output ctl_t             rctl
);

    ctl_t ctl_q [LEVELS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LEVELS; i++) begin
                ctl_q[i] <= '0;
            end
        end else if (we) begin
            ctl_q[wlvl] <= ctl_from_word(wdata);
        end
    end

    assign rctl = ctl_q[rlvl];

endmodule

// File: rtl/pgx_pte_ram.sv
module pgx_pte_ram #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 14,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/pgx_status.sv
module pgx_status #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic          ld_used,
    input  logic          ld_written,
    input  logic          set_en,
    input  logic [AW-1:0] set_addr,
    input  logic          set_written,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_used,
    output logic          rd_written
);

    logic [DEPTH-1:0] used_q;
    logic [DEPTH-1:0] written_q;

    // a table load wins over a status update to the same entry
    always_ff @(posedge clk) begin
        if (rst) begin
            used_q    <= '0;
            written_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (ld_we && ld_addr == AW'(i)) begin
                    used_q[i]    <= ld_used;
                    written_q[i] <= ld_written;
                end else if (set_en && set_addr == AW'(i)) begin
                    used_q[i] <= 1'b1;
                    if (set_written) begin
                        written_q[i] <= 1'b1;
                    end
                end
            end
        end
    end

    assign rd_used    = used_q[rd_addr];
    assign rd_written = written_q[rd_addr];

    // R7: an update without a load leaves the used bit set
    p_used_sticks_r7: assert property (@(posedge clk) disable iff (rst)
        (set_en && !ld_we) |=> used_q[$past(set_addr)]);

endmodule

// File: rtl/pgx_check.sv
module pgx_check
    import pgx_pkg::*;
(
    input  acc_e       kind,
    input  perm_t      perm,
    input  logic [1:0] user_ring,
    output verdict_e   verdict
);

    logic any_permit;
    logic has_needed;

    assign any_permit = perm.wr_ok | perm.rd_ok | perm.fe_ok;
    assign has_needed = needed_permit(kind, perm);

    // priority: empty entry, missing permit, ring
    always_comb begin
        if (!any_permit) begin
            verdict = VERD_PF;
        end else if (!has_needed) begin
            verdict = VERD_PV;
        end else if (perm.ring > user_ring) begin
            verdict = VERD_PV;
        end else begin
            verdict = VERD_OK;
        end
    end

endmodule

// File: rtl/pgx_xlate.sv
module pgx_xlate
    import pgx_pkg::*;
#(
    parameter int VA_W   = 16,
    parameter int OFS_W  = 10,
    parameter int PPN_W  = 9,
    parameter int LEVELS = 16,
    localparam int LVL_W = $clog2(LEVELS),
    localparam int PG_W  = VA_W - OFS_W,
    localparam int IDX_W = TSEL_W + PG_W,
    localparam int DEPTH = NUM_TABLES << PG_W,
    localparam int ENT_W = PERM_W + PPN_W,
    localparam int PA_W  = PPN_W + OFS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [LVL_W-1:0] cfg_lvl,
    input  logic [15:0]      cfg_data,
    input  logic             tbl_we,
    input  logic [1:0]       tbl_sel,
    input  logic [PG_W-1:0]  tbl_page,
    input  logic [15:0]      tbl_data,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    input  logic [1:0]       req_kind,
    input  logic             req_alt,
    input  logic [LVL_W-1:0] req_lvl,
    input  logic             req_pon,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_pa,
    output logic             rsp_mem,
    output logic             rsp_pf,
    output logic             rsp_pv,
    output logic             rsp_used,
    output logic             rsp_written
);

    // ---------------- request stage ----------------
    ctl_t              cur_ctl;
    acc_e              req_k;
    logic [TSEL_W-1:0] req_tbl;
    logic [IDX_W-1:0]  req_idx;

    pgx_ctl_regs #(.LEVELS(LEVELS)) u_ctl (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wlvl  (cfg_lvl),
        .wdata (cfg_data),
        .rlvl  (req_lvl),
        .rctl  (cur_ctl)
    );

    assign req_k   = acc_e'(req_kind);
    // fetches always use the normal table
    assign req_tbl = (req_alt && req_k != ACC_FETCH) ? cur_ctl.alt_tbl : cur_ctl.norm_tbl;
    assign req_idx = {req_tbl, req_va[VA_W-1:OFS_W]};

    // ---------------- entry storage ----------------
    logic [IDX_W-1:0] ld_idx;
    logic [ENT_W-1:0] ld_word;
    logic [ENT_W-1:0] ent_word;

    assign ld_idx  = {tbl_sel, tbl_page};
    assign ld_word = {perm_from_word(tbl_data), tbl_data[PPN_W-1:0]};

    pgx_pte_ram #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_ram (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (ld_idx),
        .wdata (ld_word),
        .re    (req_valid),
        .raddr (req_idx),
        .rdata (ent_word)
    );

    // ---------------- captured request ----------------
    logic             s_valid;
    logic             s_pon;
    acc_e             s_kind;
    logic [1:0]       s_ring;
    logic [IDX_W-1:0] s_idx;
    logic [VA_W-1:0]  s_va;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_valid <= 1'b0;
            s_pon   <= 1'b0;
            s_kind  <= ACC_READ;
            s_ring  <= '0;
            s_idx   <= '0;
            s_va    <= '0;
        end else begin
            s_valid <= req_valid;
            if (req_valid) begin
                s_pon  <= req_pon;
                s_kind <= req_k;
                s_ring <= cur_ctl.ring;
                s_idx  <= req_idx;
                s_va   <= req_va;
            end
        end
    end

    // ---------------- response stage ----------------
    perm_t            ent_perm;
    logic [PPN_W-1:0] ent_ppn;
    verdict_e         verdict;
    logic             paged;
    logic             grant;
    logic             cur_used;
    logic             cur_written;

    assign ent_perm = perm_t'(ent_word[ENT_W-1:PPN_W]);
    assign ent_ppn  = ent_word[PPN_W-1:0];

    pgx_check u_chk (
        .kind      (s_kind),
        .perm      (ent_perm),
        .user_ring (s_ring),
        .verdict   (verdict)
    );

    assign paged = s_valid && s_pon;
    assign grant = paged && verdict == VERD_OK;

    pgx_status #(.DEPTH(DEPTH)) u_sts (
        .clk         (clk),
        .rst         (rst),
        .ld_we       (tbl_we),
        .ld_addr     (ld_idx),
        .ld_used     (tbl_data[E_USED]),
        .ld_written  (tbl_data[E_WRITTEN]),
        .set_en      (grant),
        .set_addr    (s_idx),
        .set_written (s_kind == ACC_WRITE),
        .rd_addr     (s_idx),
        .rd_used     (cur_used),
        .rd_written  (cur_written)
    );

    assign rsp_valid   = s_valid;
    assign rsp_pa      = s_pon ? {ent_ppn, s_va[OFS_W-1:0]} : PA_W'(s_va);
    assign rsp_mem     = s_valid && (!s_pon || verdict == VERD_OK);
    assign rsp_pf      = paged && verdict == VERD_PF;
    assign rsp_pv      = paged && verdict == VERD_PV;
    assign rsp_used    = s_pon && (cur_used || grant);
    assign rsp_written = s_pon && (cur_written || (grant && s_kind == ACC_WRITE));

    logic unused_cfg;
    assign unused_cfg = ^{cfg_data[15:11], cfg_data[6:2], tbl_data[E_RING_LO-1:0]};

    // ---------------- assertions ----------------
    p_latency_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_one_fault_r4: assert property (@(posedge clk) disable iff (rst)
        !(rsp_pf && rsp_pv));

    p_no_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_pf || rsp_pv) |-> !rsp_mem);

    p_offset_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_pa[OFS_W-1:0] == $past(req_va[OFS_W-1:0]));

    p_bypass_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_pon) |=>
            (rsp_pa == PA_W'($past(req_va)) && rsp_mem && !rsp_pf && !rsp_pv));

endmodule

// File: tb/sim_pgx_xlate.sv
module sim_pgx_xlate;

    localparam int CLK_PERIOD = 10;
    localparam int VA_W = 16, OFS_W = 10, PPN_W = 9, LEVELS = 16;
    localparam int PG_W = VA_W - OFS_W;
    localparam int PA_W = PPN_W + OFS_W;
    localparam int PAGES = 1 << PG_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [3:0] cfg_lvl = '0;
    logic [15:0] cfg_data = '0;
    logic tbl_we = 1'b0;
    logic [1:0] tbl_sel = '0;
    logic [PG_W-1:0] tbl_page = '0;
    logic [15:0] tbl_data = '0;
    logic req_valid = 1'b0;
    logic [VA_W-1:0] req_va = '0;
    logic [1:0] req_kind = '0;
    logic req_alt = 1'b0;
    logic [3:0] req_lvl = '0;
    logic req_pon = 1'b0;
    logic rsp_valid, rsp_mem, rsp_pf, rsp_pv, rsp_used, rsp_written;
    logic [PA_W-1:0] rsp_pa;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgx_xlate #(.VA_W(VA_W), .OFS_W(OFS_W), .PPN_W(PPN_W), .LEVELS(LEVELS)) u0 (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_lvl(cfg_lvl), .cfg_data(cfg_data),
        .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_page(tbl_page), .tbl_data(tbl_data),
        .req_valid(req_valid), .req_va(req_va), .req_kind(req_kind), .req_alt(req_alt),
        .req_lvl(req_lvl), .req_pon(req_pon),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_mem(rsp_mem), .rsp_pf(rsp_pf),
        .rsp_pv(rsp_pv), .rsp_used(rsp_used), .rsp_written(rsp_written)
    );

    int n_checks = 0;
    int n_fail = 0;

    // bench model of the status bits
    bit m_used [4][PAGES];
    bit m_wrt  [4][PAGES];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // entry pattern, computed from table and page
    function automatic int code_of(input int t, input int p);
        return t * PAGES + p;
    endfunction
    function automatic int perm_of(input int t, input int p); return code_of(t, p) % 8; endfunction
    function automatic int ring_of(input int t, input int p); return (code_of(t, p) / 8) % 4; endfunction
    function automatic int ppn_of(input int t, input int p);  return (code_of(t, p) * 37 + 5) % 512; endfunction

    // level control pattern
    function automatic int norm_of(input int l); return l % 4; endfunction
    function automatic int alt_of(input int l);  return (l + 1) % 4; endfunction
    function automatic int uring_of(input int l); return (l / 4) % 4; endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    task automatic access(input int lvl, input int va, input int kind, input bit alt, input bit pon);
        int tbl, pg, perm, ring, ur, exp_pa;
        bit need, exp_pf, exp_pv, exp_ok, exp_u, exp_w;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R10 idle valid", rsp_valid, 0);
        req_valid = 1'b1; req_va = VA_W'(va); req_kind = 2'(kind);
        req_alt = alt; req_lvl = 4'(lvl); req_pon = pon;
        @(negedge clk);
        req_valid = 1'b0;
        pg = va >> OFS_W;
        tbl = (alt && kind != 1) ? alt_of(lvl) : norm_of(lvl);
        chk(rsp_valid == 1'b1, "R10 response valid", rsp_valid, 1);
        if (!pon) begin
            chk(rsp_pa == PA_W'(va), "R9 bypass address", rsp_pa, va);
            chk(rsp_mem && !rsp_pf && !rsp_pv, "R9 bypass no fault",
                {rsp_mem, rsp_pf, rsp_pv}, 3'b100);
            chk(!rsp_used && !rsp_written, "R9 status read zero", {rsp_used, rsp_written}, 0);
            return;
        end
        perm = perm_of(tbl, pg);
        ring = ring_of(tbl, pg);
        ur = uring_of(lvl);
        // perm bit0 write, bit1 read, bit2 fetch
        need = (kind == 1) ? perm[2] : (kind == 2) ? perm[0] : perm[1];
        exp_pf = (perm == 0);
        exp_pv = !exp_pf && (!need || ring > ur);
        exp_ok = !exp_pf && !exp_pv;
        if (exp_ok) begin
            m_used[tbl][pg] = 1'b1;
            if (kind == 2) m_wrt[tbl][pg] = 1'b1;
        end
        exp_u = m_used[tbl][pg];
        exp_w = m_wrt[tbl][pg];
        exp_pa = (ppn_of(tbl, pg) << OFS_W) | (va % (1 << OFS_W));
        chk(rsp_pf == exp_pf, "R4 page fault", rsp_pf, exp_pf);
        if (!need && !exp_pf)
            chk(rsp_pv == exp_pv, "R5 permit violation", rsp_pv, exp_pv);
        else
            chk(rsp_pv == exp_pv, "R6 ring violation", rsp_pv, exp_pv);
        chk(rsp_mem == exp_ok, "R8 strobe", rsp_mem, exp_ok);
        if (exp_ok)
            chk(rsp_pa == PA_W'(exp_pa), alt ? "R3 alternate address" : "R1 R2 address",
                rsp_pa, exp_pa);
        chk(rsp_used == exp_u, exp_ok ? "R7 used" : "R8 R12 used kept", rsp_used, exp_u);
        chk(rsp_written == exp_w, exp_ok ? "R7 written" : "R8 R12 written kept",
            rsp_written, exp_w);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11: idle after reset
        chk(!rsp_valid && !rsp_mem && !rsp_pf && !rsp_pv, "R11 reset outputs",
            {rsp_valid, rsp_mem, rsp_pf, rsp_pv}, 0);

        // R2: control registers, with noise in the discarded bits
        for (int l = 0; l < LEVELS; l++) begin
            @(negedge clk);
            cfg_we = 1'b1; cfg_lvl = 4'(l);
            cfg_data = 16'hF87C | 16'(norm_of(l) << 9) | 16'(alt_of(l) << 7) | 16'(uring_of(l));
            cfg_data[10:9] = 2'(norm_of(l));
            cfg_data[8:7] = 2'(alt_of(l));
            cfg_data[1:0] = 2'(uring_of(l));
        end
        @(negedge clk); cfg_we = 1'b0;

        // R12: table entries with initial status from bits 12 and 11
        for (int t = 0; t < 4; t++) begin
            for (int p = 0; p < PAGES; p++) begin
                int pm;
                pm = perm_of(t, p);
                m_used[t][p] = (code_of(t, p) % 5 == 0);
                m_wrt[t][p]  = (code_of(t, p) % 7 == 0);
                @(negedge clk);
                tbl_we = 1'b1; tbl_sel = 2'(t); tbl_page = PG_W'(p);
                tbl_data = '0;
                tbl_data[15] = pm[0];
                tbl_data[14] = pm[1];
                tbl_data[13] = pm[2];
                tbl_data[12] = m_wrt[t][p];
                tbl_data[11] = m_used[t][p];
                tbl_data[10:9] = 2'(ring_of(t, p));
                tbl_data[8:0] = 9'(ppn_of(t, p));
            end
        end
        @(negedge clk); tbl_we = 1'b0;

        // R9: paging off, writes everywhere must leave status untouched
        for (int p = 0; p < PAGES; p++) begin
            access(p % LEVELS, (p << OFS_W) | ((p * 29) % 1024), 2, p[0], 1'b0);
        end

        // R1..R8: full sweep of level, page, kind and alternate flag
        for (int l = 0; l < LEVELS; l++) begin
            for (int p = 0; p < PAGES; p++) begin
                for (int k = 0; k < 3; k++) begin
                    for (int a = 0; a < 2; a++) begin
                        access(l, (p << OFS_W) | ((p * 13 + l * 5 + k) % 1024), k, a[0], 1'b1);
                    end
                end
            end
        end

        @(negedge clk);
        chk(rsp_valid == 1'b0, "R10 final idle", rsp_valid, 0);
        summary();
        $finish;
    end

endmodule